// File: doc/BRIEF.md
# SPI Command/Response Mailbox Bridge

This block carries short ASCII command strings from a synchronous host register port to an external microcontroller, and carries the replies back. The host writes command bytes, one at a time, into a command FIFO. An interrupt line tells the microcontroller that something is waiting. The microcontroller acts as SPI master: it drains the command FIFO, runs the command, and writes the response bytes into a result FIFO. The host then pulls the response out one byte per read.

Both FIFOs sit behind one host address. A write to that address feeds the command FIFO and a read from it drains the result FIFO. A command string ends with a carriage return (0x0D) or a line feed (0x0A) and stays under 512 bytes. The block passes the bytes through and does not parse them.

The SPI side is a mode-0 slave. SCLK, MOSI and chip-select are brought into the system clock through two-flop synchronisers. The system clock must run at least 8 times faster than SCLK. Both FIFO depths must be powers of two; the default for each is 2048 bytes.

Top module: `spi_mailbox_bridge`

## Requirements
- R1: A host write to the mailbox address pushes `host_wdata` into the command FIFO. `spi_irq` is high exactly while the command FIFO holds at least one byte, and it follows a push on the next clock.
- R2: A host read from the mailbox address pops the oldest result byte. That byte is on `host_rdata` after the clock edge that samples the request, and bytes come out in the order they were written.
- R3: A host read from the mailbox address while the result FIFO is empty returns 0xFF and changes no FIFO state.
- R4: A host access to any other address has no effect on either FIFO. A read of another address returns 0x00.
- R5: A host write to a full command FIFO, or an SPI result byte arriving at a full result FIFO, is dropped and sets a sticky overflow flag.
- R6: SPI is mode 0 (SCLK idles low, data sampled on the rising edge, changed on the falling edge) and MSB first. The first byte after chip-select falls is an opcode. After opcode 0x01, each following byte shifts out the oldest command byte, and that byte is popped once its eighth bit has been clocked.
- R7: During an opcode 0x01 transaction, a byte slot that starts while the command FIFO is empty shifts out 0xFF and pops nothing.
- R8: After opcode 0x02, each complete byte received on MOSI is pushed into the result FIFO.
- R9: After opcode 0x03, each byte shifted out is a status byte: bit 0 is command-FIFO empty, bit 1 is result-FIFO full, bit 2 is the overflow flag, and bits 7..3 are zero. Shifting out a status byte clears the overflow flag.
- R10: Chip-select rising in the middle of a byte discards the partial byte. The next byte after chip-select falls again is taken as an opcode.
- R11: Any other opcode makes the rest of the transaction a no-op: MISO shifts out 0xFF and no FIFO changes. MISO also shifts 0xFF while the opcode byte is being received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Host address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, registered |
| spi_sclk | input | 1 | SPI clock from the master |
| spi_mosi | input | 1 | SPI data from the master |
| spi_cs_n | input | 1 | SPI chip-select, active low |
| spi_miso | output | 1 | SPI data to the master |
| spi_irq | output | 1 | Command-waiting interrupt to the microcontroller |

## Verification
Host results have fixed timing. A read byte is on `host_rdata`, and a push shows on `spi_irq`, right after the clock edge that samples the request, so the bench checks both on the next falling clock edge. An SPI edge takes effect three system clocks after it reaches the pins: two synchroniser stages plus the edge register. The bench therefore holds each SCLK phase for eight clocks and samples MISO just before it drives the rising edge. The cycle-by-cycle comparison of `spi_irq` against the queue model pauses while a host or SPI operation is still settling, and resumes once those three cycles have passed.

// File: rtl/spi_mailbox_bridge.sv
module spi_mailbox_bridge #(
  parameter int unsigned CMD_DEPTH = 2048,
  parameter int unsigned RES_DEPTH = 2048,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned MBOX_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  input  logic              spi_cs_n,
  output logic              spi_miso,
  output logic              spi_irq
);
  localparam int unsigned CAW = $clog2(CMD_DEPTH);
  localparam int unsigned RAW = $clog2(RES_DEPTH);

  typedef enum logic [2:0] {ST_OP, ST_CMD, ST_RES, ST_STAT, ST_SKIP} st_t;

  logic [7:0] cmd_mem [CMD_DEPTH];
  logic [7:0] res_mem [RES_DEPTH];
  logic [CAW-1:0] cmd_wp, cmd_rp;
  logic [RAW-1:0] res_wp, res_rp;
  logic [CAW:0] cmd_cnt;
  logic [RAW:0] res_cnt;
  logic ovf;

  logic [2:0] sclk_s, cs_s;
  logic [1:0] mosi_s;
  st_t st;
  logic [2:0] bitcnt;
  logic [6:0] rx_sh;
  logic [7:0] tx_sh;
  logic tx_real;

  wire cmd_empty = (cmd_cnt == '0);
  wire cmd_full  = (cmd_cnt == (CAW+1)'(CMD_DEPTH));
  wire res_empty = (res_cnt == '0);
  wire res_full  = (res_cnt == (RAW+1)'(RES_DEPTH));

  wire host_hit  = host_req && (host_addr == ADDR_W'(MBOX_ADDR));
  wire cs_act    = ~cs_s[1];
  wire cs_edge   = cs_s[1] ^ cs_s[2];
  wire sclk_rise = cs_act &&  sclk_s[1] && !sclk_s[2];
  wire sclk_fall = cs_act && !sclk_s[1] &&  sclk_s[2];
  wire [7:0] rx_byte = {rx_sh, mosi_s[1]};
  wire byte_done = sclk_rise && (bitcnt == 3'd7);
  wire load_slot = sclk_fall && (bitcnt == 3'd0);
  wire [7:0] status = {5'b0, ovf, res_full, cmd_empty};

  wire cmd_push = host_hit && host_wr && !cmd_full;
  wire cmd_pop  = byte_done && (st == ST_CMD) && tx_real;
  wire res_push = byte_done && (st == ST_RES) && !res_full;
  wire res_pop  = host_hit && !host_wr && !res_empty;
  wire ovf_set  = (host_hit && host_wr && cmd_full) || (byte_done && (st == ST_RES) && res_full);
  wire ovf_clr  = load_slot && (st == ST_STAT) && !cs_edge;

  assign spi_irq  = ~cmd_empty;
  assign spi_miso = tx_sh[7];

  always_ff @(posedge clk) begin
    if (cmd_push) cmd_mem[cmd_wp] <= host_wdata;
    if (res_push) res_mem[res_wp] <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_wp <= '0; cmd_rp <= '0; cmd_cnt <= '0;
      res_wp <= '0; res_rp <= '0; res_cnt <= '0;
      ovf <= 1'b0;
      host_rdata <= 8'h00;
    end else begin
      if (cmd_push) cmd_wp <= cmd_wp + 1'b1;
      if (cmd_pop)  cmd_rp <= cmd_rp + 1'b1;
      if (res_push) res_wp <= res_wp + 1'b1;
      if (res_pop)  res_rp <= res_rp + 1'b1;
      case ({cmd_push, cmd_pop})
        2'b10:   cmd_cnt <= cmd_cnt + 1'b1;
        2'b01:   cmd_cnt <= cmd_cnt - 1'b1;
        default: cmd_cnt <= cmd_cnt;
      endcase
      case ({res_push, res_pop})
        2'b10:   res_cnt <= res_cnt + 1'b1;
        2'b01:   res_cnt <= res_cnt - 1'b1;
        default: res_cnt <= res_cnt;
      endcase
      if (ovf_set)      ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
      if (host_hit && !host_wr)      host_rdata <= res_empty ? 8'hFF : res_mem[res_rp];
      else if (host_req && !host_wr) host_rdata <= 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s <= '0; cs_s <= '1; mosi_s <= '0;
    end else begin
      sclk_s <= {sclk_s[1:0], spi_sclk};
      cs_s   <= {cs_s[1:0], spi_cs_n};
      mosi_s <= {mosi_s[0], spi_mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_OP; bitcnt <= '0; rx_sh <= '0; tx_sh <= 8'hFF; tx_real <= 1'b0;
    end else if (cs_edge) begin
      st <= ST_OP; bitcnt <= '0; tx_sh <= 8'hFF; tx_real <= 1'b0;
    end else begin
      if (sclk_rise) begin
        rx_sh  <= rx_byte[6:0];
        bitcnt <= bitcnt + 3'd1;
        if (byte_done && st == ST_OP) begin
          case (rx_byte)
            8'h01:   st <= ST_CMD;
            8'h02:   st <= ST_RES;
            8'h03:   st <= ST_STAT;
            default: st <= ST_SKIP;
          endcase
        end
        if (cmd_pop) tx_real <= 1'b0;
      end
      if (load_slot) begin
        case (st)
          ST_CMD: begin
            tx_sh   <= cmd_empty ? 8'hFF : cmd_mem[cmd_rp];
            tx_real <= !cmd_empty;
          end
          ST_STAT: begin
            tx_sh   <= status;
            tx_real <= 1'b0;
          end
          default: begin
            tx_sh   <= 8'hFF;
            tx_real <= 1'b0;
          end
        endcase
      end else if (sclk_fall) begin
        tx_sh <= {tx_sh[6:0], 1'b1};
      end
    end
  end

  AST_CMD_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cmd_cnt <= (CAW+1)'(CMD_DEPTH)); // R5
  AST_RES_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) res_cnt <= (RAW+1)'(RES_DEPTH)); // R5
  AST_FULL_WRITE_OVF: assert property (@(posedge clk) disable iff (!rst_n) (host_hit && host_wr && cmd_full) |=> ovf); // R5
  AST_EMPTY_READ_FF: assert property (@(posedge clk) disable iff (!rst_n) (host_hit && !host_wr && res_empty) |=> (host_rdata == 8'hFF)); // R3
  AST_IRQ_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n) $rose(spi_irq) |-> $past(host_hit && host_wr)); // R1
  AST_CS_RESTART: assert property (@(posedge clk) disable iff (!rst_n) cs_edge |=> (bitcnt == 3'd0 && st == ST_OP)); // R10
  AST_MISC_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (host_req && !host_wr && !host_hit) |=> (host_rdata == 8'h00)); // R4
endmodule

// File: tb/tb_spi_mailbox_bridge.sv
module tb_spi_mailbox_bridge;
  localparam int DEPTH = 16;
  localparam int HALF  = 8;
  localparam logic [7:0] MBOX  = 8'h20;
  localparam logic [7:0] OTHER = 8'h21;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_req = 1'b0, host_wr = 1'b0;
  logic [7:0] host_addr = '0, host_wdata = '0, host_rdata;
  logic spi_sclk = 1'b0, spi_mosi = 1'b0, spi_cs_n = 1'b1, spi_miso, spi_irq;

  spi_mailbox_bridge #(.CMD_DEPTH(DEPTH), .RES_DEPTH(DEPTH), .ADDR_W(8), .MBOX_ADDR(32)) dut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_cs_n(spi_cs_n), .spi_miso(spi_miso), .spi_irq(spi_irq));

  always #2.5 clk = ~clk;

  int compared = 0, mismatched = 0;
  logic busy = 1'b1, ran = 1'b0, finished = 1'b0;
  logic [7:0] cmd_q[$];
  logic [7:0] res_q[$];
  logic ovf_m = 1'b0;

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(negedge clk) begin
    if (ran && !busy) check8("R1 irq", {7'b0, spi_irq}, {7'b0, cmd_q.size() != 0});
  end

  task automatic host_write(input logic [7:0] a, input logic [7:0] d);
    busy = 1'b1;
    host_req = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_req = 1'b0; host_wr = 1'b0;
    if (a == MBOX) begin
      if (cmd_q.size() < DEPTH) cmd_q.push_back(d);
      else ovf_m = 1'b1;
    end
    @(negedge clk);
    busy = 1'b0;
  endtask

  task automatic host_read(input logic [7:0] a, input string req);
    logic [7:0] exp;
    busy = 1'b1;
    host_req = 1'b1; host_wr = 1'b0; host_addr = a;
    @(negedge clk);
    host_req = 1'b0;
    if (a != MBOX) exp = 8'h00;
    else if (res_q.size() == 0) exp = 8'hFF;
    else exp = res_q.pop_front();
    check8(req, host_rdata, exp);
    @(negedge clk);
    busy = 1'b0;
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i > 7 - n; i--) begin
      spi_mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = spi_miso;
      spi_sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b0;
    end
  endtask

  task automatic cs_low();
    busy = 1'b1;
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_high();
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (HALF + 4) @(negedge clk);
    busy = 1'b0;
  endtask

  task automatic spi_cmd_read(input int n, input string req);
    logic [7:0] rx;
    cs_low();
    spi_bits(8'h01, 8, rx);
    check8("R11 opcode slot", rx, 8'hFF);
    for (int k = 0; k < n; k++) begin
      spi_bits(8'h00, 8, rx);
      if (cmd_q.size() == 0) check8({req, " R7"}, rx, 8'hFF);
      else check8(req, rx, cmd_q.pop_front());
    end
    cs_high();
  endtask

  task automatic spi_res_write(input logic [7:0] b[$]);
    logic [7:0] rx;
    cs_low();
    spi_bits(8'h02, 8, rx);
    foreach (b[k]) begin
      spi_bits(b[k], 8, rx);
      if (res_q.size() < DEPTH) res_q.push_back(b[k]);
      else ovf_m = 1'b1;
    end
    cs_high();
  endtask

  task automatic spi_status(input string req);
    logic [7:0] rx;
    cs_low();
    spi_bits(8'h03, 8, rx);
    spi_bits(8'h00, 8, rx);
    check8(req, rx, {5'b0, ovf_m, res_q.size() == DEPTH, cmd_q.size() == 0});
    ovf_m = 1'b0;
    cs_high();
  endtask

  initial begin
    logic [7:0] rx;
    logic [7:0] bytes[$];
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check8("R1 reset irq", {7'b0, spi_irq}, 8'h00);
    check8("R11 reset miso", {7'b0, spi_miso}, 8'h01);
    check8("R2 reset rdata", host_rdata, 8'h00);
    ran = 1'b1; busy = 1'b0;

    host_read(MBOX, "R3 empty read");
    host_read(MBOX, "R3 empty read again");
    spi_status("R9 idle status");

    host_write(MBOX, 8'h41);
    check8("R1 irq after push", {7'b0, spi_irq}, 8'h01);
    host_write(MBOX, 8'h42);
    host_write(OTHER, 8'h99);
    host_write(MBOX, 8'h0D);
    host_read(OTHER, "R4 other read");
    spi_cmd_read(5, "R6 cmd bytes");
    check8("R1 irq after drain", {7'b0, spi_irq}, 8'h00);

    bytes = '{8'h4F, 8'h4B, 8'h0A};
    spi_res_write(bytes);
    host_read(MBOX, "R2 res byte0");
    host_read(MBOX, "R2 res byte1");
    host_read(MBOX, "R8 res byte2");
    host_read(MBOX, "R3 res drained");

    for (int k = 0; k <= DEPTH; k++) host_write(MBOX, 8'(8'h60 + k));
    spi_status("R5 R9 cmd overflow status");
    spi_status("R9 overflow cleared");
    spi_cmd_read(DEPTH + 1, "R5 cmd after drop");

    bytes = {};
    for (int k = 0; k <= DEPTH; k++) bytes.push_back(8'(8'h80 + 3 * k));
    spi_res_write(bytes);
    spi_status("R5 R9 res overflow status");
    for (int k = 0; k <= DEPTH; k++) host_read(MBOX, "R5 res after drop");

    cs_low();
    spi_bits(8'h02, 8, rx);
    spi_bits(8'hA5, 4, rx);
    cs_high();
    host_read(MBOX, "R10 partial byte dropped");
    cs_low();
    spi_bits(8'h01, 5, rx);
    cs_high();
    host_write(MBOX, 8'h33);
    spi_cmd_read(1, "R10 opcode after restart");

    host_write(MBOX, 8'h34);
    cs_low();
    spi_bits(8'h55, 8, rx);
    spi_bits(8'h12, 8, rx);
    check8("R11 unknown opcode miso", rx, 8'hFF);
    spi_bits(8'h34, 8, rx);
    check8("R11 unknown opcode miso 2", rx, 8'hFF);
    cs_high();
    host_read(MBOX, "R11 no result push");
    spi_cmd_read(1, "R11 cmd untouched");

    repeat (4) @(negedge clk);
    finished = 1'b1;
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule